// File: doc/BRIEF.md
# Parallel Bus Listener with Byte Handshake

This block is the receiving side of a byte-wide parallel instrument bus. The bus carries an attention line, a data-valid strobe and eight data lines. The block answers on two lines: ready-for-data and data-accepted. While attention is asserted, every byte the controller sends is a command. The block checks each command against a five-bit device address taken from static switch inputs, and it keeps two flags that say whether the device is addressed to listen and whether it is addressed to talk. While attention is deasserted and the device is a listener, bytes are data. The block takes each one through the three-wire interlock and stores it in a receive register.

A local processor on the same clock reads the block through an active-low select, a read/write line and a three-bit register select. Reading the receive register consumes the byte. The block does not offer ready-for-data again for data until that read has happened, so a byte is never overwritten before the processor has taken it. Every bus input passes through a synchronizer before the handshake logic sees it.

Top module: `pbus_listener`

## Requirements
- R1: After reset, ready-for-data and data-accepted are low and the status register reads 0x00.
- R2: While the block takes part in a transfer, it raises ready-for-data with data-accepted low. When it sees data-valid, it drops ready-for-data, captures the data lines and raises data-accepted.
- R3: Data-accepted falls only after data-valid has gone low. Ready-for-data and data-accepted are never high together.
- R4: Under attention, a byte whose low seven bits equal 0x20 | device address sets the listen flag (status bit 1). Bit 7 of a command byte is ignored, and a listen address for another device leaves the flag unchanged.
- R5: Under attention, a byte whose low seven bits are 0x40 | device address sets the talk flag (status bit 2). A talk address for any other device clears the flag, and 0x5F clears it.
- R6: Under attention, 0x3F clears the listen flag. It takes precedence over a listen match, so device address 31 can never become a listener.
- R7: With attention low, a byte is handshaken only when the listen flag is set. A device that is not a listener keeps both of its handshake outputs low even while data-valid is high.
- R8: A byte accepted with attention low is read at register select 0 and sets data-available (status bit 0). Status is read at register select 1.
- R9: After a data byte is accepted, ready-for-data stays low while attention is low until the processor reads register select 0. Ready-for-data is then raised again.
- R10: A read is select low with read/write high. Its data appears on the read port one clock later. Reading select 0 clears data-available, reading select 1 does not, and selects 2 to 7 read 0x00. With select high, nothing changes.
- R11: An access with read/write low changes neither the receive register nor any status flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_atn_i | input | 1 | Attention: bytes are commands while high |
| bus_dav_i | input | 1 | Data-valid strobe from the controller |
| bus_data_i | input | 8 | Bus data lines |
| bus_rfd_o | output | 1 | Ready-for-data |
| bus_dac_o | output | 1 | Data-accepted |
| dev_addr_i | input | 5 | Device address from switches, static |
| cpu_cs_n_i | input | 1 | Processor select, active low |
| cpu_rw_i | input | 1 | 1 = read, 0 = write |
| cpu_rs_i | input | 3 | Register select |
| cpu_rdata_o | output | 8 | Registered read data |

## Verification
The assertions assume that the controller obeys the interlock: it raises data-valid only after it has seen ready-for-data, keeps the data lines stable while data-valid is high, and lowers data-valid only after it has seen data-accepted. They also assume that the device address changes only while no transfer is in progress. The stimulus runs every byte through one bench task that waits for each handshake edge before it moves the next line. Attention is changed only between transfers, and the task then waits several cycles before it starts. The switch value is changed only during idle periods under attention.

// File: rtl/pbl_pkg.sv
package pbl_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;
    localparam int RS_W   = 3;
    localparam int CMD_W  = ADDR_W + 2;

    localparam logic [1:0]       GRP_LISTEN   = 2'b01;
    localparam logic [1:0]       GRP_TALK     = 2'b10;
    localparam logic [CMD_W-1:0] CMD_UNLISTEN = 7'h3F;
    localparam logic [CMD_W-1:0] CMD_UNTALK   = 7'h5F;

    localparam logic [RS_W-1:0]  SEL_RXDATA = 3'd0;
    localparam logic [RS_W-1:0]  SEL_STATUS = 3'd1;

    typedef enum logic [1:0] {
        HS_WAIT   = 2'd0,
        HS_READY  = 2'd1,
        HS_ACCEPT = 2'd2
    } hs_state_e;
endpackage

// File: rtl/pbl_sync.sv
module pbl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [W-1:0] in_w;
            if (g == 0) begin : g_first
                assign in_w = d_i;
            end else begin : g_rest
                assign in_w = stage_q[g-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else begin
                    stage_q[g] <= in_w;
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pbl_handshake.sv
module pbl_handshake
    import pbl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic atn_s_i,
    input  logic dav_s_i,
    input  logic listen_i,
    input  logic avail_i,
    output logic rfd_o,
    output logic dac_o,
    output logic cmd_stb_o,
    output logic data_stb_o
);
    typedef struct packed {
        hs_state_e state;
    } hs_reg_t;

    hs_reg_t st_d, st_q;
    logic    engage;

    always_comb begin
        st_d       = st_q;
        cmd_stb_o  = 1'b0;
        data_stb_o = 1'b0;
        engage     = atn_s_i || (listen_i && !avail_i);
        unique case (st_q.state)
            HS_WAIT: begin
                if (engage) begin
                    st_d.state = HS_READY;
                end
            end
            HS_READY: begin
                if (!engage) begin
                    st_d.state = HS_WAIT;
                end else if (dav_s_i) begin
                    cmd_stb_o  = atn_s_i;
                    data_stb_o = !atn_s_i;
                    st_d.state = HS_ACCEPT;
                end
            end
            HS_ACCEPT: begin
                if (!dav_s_i) begin
                    st_d.state = HS_WAIT;
                end
            end
            default: st_d.state = HS_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= HS_WAIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign rfd_o = (st_q.state == HS_READY);
    assign dac_o = (st_q.state == HS_ACCEPT);
endmodule

// File: rtl/pbl_addr_decode.sv
module pbl_addr_decode
    import pbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_stb_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    output logic              listen_o,
    output logic              talk_o
);
    typedef struct packed {
        logic listen;
        logic talk;
    } ad_reg_t;

    ad_reg_t st_d, st_q;
    logic [1:0] grp;
    logic       own;

    always_comb begin
        st_d = st_q;
        grp  = cmd_i[CMD_W-1:ADDR_W];
        own  = (cmd_i[ADDR_W-1:0] == dev_addr_i);
        if (cmd_stb_i) begin
            if (cmd_i == CMD_UNLISTEN) begin
                st_d.listen = 1'b0;
            end else if (grp == GRP_LISTEN && own) begin
                st_d.listen = 1'b1;
            end
            if (cmd_i == CMD_UNTALK) begin
                st_d.talk = 1'b0;
            end else if (grp == GRP_TALK) begin
                st_d.talk = own;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign listen_o = st_q.listen;
    assign talk_o   = st_q.talk;
endmodule

// File: rtl/pbl_regfile.sv
module pbl_regfile
    import pbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_stb_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              listen_i,
    input  logic              talk_i,
    input  logic              cs_n_i,
    input  logic              rw_i,
    input  logic [RS_W-1:0]   rs_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              avail_o
);
    localparam int PAD_W = BYTE_W - 3;

    typedef struct packed {
        logic [BYTE_W-1:0] rx;
        logic              avail;
        logic [BYTE_W-1:0] rdata;
    } rf_reg_t;

    rf_reg_t st_d, st_q;
    logic    rd;
    logic [BYTE_W-1:0] status;

    always_comb begin
        st_d   = st_q;
        rd     = !cs_n_i && rw_i;
        status = {{PAD_W{1'b0}}, talk_i, listen_i, st_q.avail};
        if (rd) begin
            unique case (rs_i)
                SEL_RXDATA: begin
                    st_d.rdata = st_q.rx;
                    st_d.avail = 1'b0;
                end
                SEL_STATUS: st_d.rdata = status;
                default:    st_d.rdata = '0;
            endcase
        end
        if (data_stb_i) begin
            st_d.rx    = data_i;
            st_d.avail = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;
    assign avail_o = st_q.avail;
endmodule

// File: rtl/pbus_listener.sv
module pbus_listener
    import pbl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_atn_i,
    input  logic              bus_dav_i,
    input  logic [7:0]        bus_data_i,
    output logic              bus_rfd_o,
    output logic              bus_dac_o,
    input  logic [4:0]        dev_addr_i,
    input  logic              cpu_cs_n_i,
    input  logic              cpu_rw_i,
    input  logic [2:0]        cpu_rs_i,
    output logic [7:0]        cpu_rdata_o
);
    localparam int SYNC_W = BYTE_W + 2;

    logic [SYNC_W-1:0] sync_in, sync_out;
    logic              atn_s, dav_s;
    logic [BYTE_W-1:0] data_s;
    logic              listen, talk, avail;
    logic              cmd_stb, data_stb;

    assign sync_in = {bus_atn_i, bus_dav_i, bus_data_i};

    pbl_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sync_in),
        .q_o   (sync_out)
    );

    assign {atn_s, dav_s, data_s} = sync_out;

    pbl_handshake hs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .atn_s_i    (atn_s),
        .dav_s_i    (dav_s),
        .listen_i   (listen),
        .avail_i    (avail),
        .rfd_o      (bus_rfd_o),
        .dac_o      (bus_dac_o),
        .cmd_stb_o  (cmd_stb),
        .data_stb_o (data_stb)
    );

    pbl_addr_decode dec_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_stb_i  (cmd_stb),
        .cmd_i      (data_s[CMD_W-1:0]),
        .dev_addr_i (dev_addr_i),
        .listen_o   (listen),
        .talk_o     (talk)
    );

    pbl_regfile rf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_stb_i (data_stb),
        .data_i     (data_s),
        .listen_i   (listen),
        .talk_i     (talk),
        .cs_n_i     (cpu_cs_n_i),
        .rw_i       (cpu_rw_i),
        .rs_i       (cpu_rs_i),
        .rdata_o    (cpu_rdata_o),
        .avail_o    (avail)
    );
endmodule

// File: rtl/pbus_listener_chk.sv
module pbus_listener_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rfd,
    input logic       dac,
    input logic       atn_s,
    input logic       dav_s,
    input logic       listen,
    input logic       avail,
    input logic       data_stb,
    input logic       cs_n,
    input logic       rw,
    input logic [2:0] rs
);
    // R3
    rfd_dac_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rfd && dac));

    // R2
    dac_after_rfd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac) |-> $past(rfd));

    // R3
    dac_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac) |-> !$past(dav_s));

    // R9
    rfd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (avail && !atn_s && $past(!atn_s)) |-> !rfd);

    // R7
    data_only_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |-> (listen && !atn_s));

    // R10
    rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rw && rs == 3'd0 && !data_stb) |=> !avail);
endmodule

bind pbus_listener pbus_listener_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rfd      (bus_rfd_o),
    .dac      (bus_dac_o),
    .atn_s    (atn_s),
    .dav_s    (dav_s),
    .listen   (listen),
    .avail    (avail),
    .data_stb (data_stb),
    .cs_n     (cpu_cs_n_i),
    .rw       (cpu_rw_i),
    .rs       (cpu_rs_i)
);

// File: tb/pbus_listener_tb_top.sv
module pbus_listener_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       atn = 1'b0, dav = 1'b0;
    logic [7:0] dbus = 8'h00;
    logic [4:0] addr_sw = 5'd9;
    logic       cs_n = 1'b1, rw = 1'b1;
    logic [2:0] rs = 3'd0;
    logic       rfd, dac;
    logic [7:0] rdata;

    int  checks = 0, failures = 0, cyc = 0;
    bit  done = 1'b0;
    bit  exp_listen = 0, exp_talk = 0, exp_avail = 0;
    logic [7:0] exp_rx = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbus_listener dut_i (
        .clk(clk), .rst_n(rst_n), .bus_atn_i(atn), .bus_dav_i(dav),
        .bus_data_i(dbus), .bus_rfd_o(rfd), .bus_dac_o(dac),
        .dev_addr_i(addr_sw), .cpu_cs_n_i(cs_n), .cpu_rw_i(rw),
        .cpu_rs_i(rs), .cpu_rdata_o(rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIMIT && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic bit model_listen(input logic [7:0] b, input bit cur, input logic [4:0] a);
        logic [6:0] c = b[6:0];
        if (c == 7'h3F) return 1'b0;
        if (c == {2'b01, a}) return 1'b1;
        return cur;
    endfunction

    function automatic bit model_talk(input logic [7:0] b, input bit cur, input logic [4:0] a);
        logic [6:0] c = b[6:0];
        if (c == 7'h5F) return 1'b0;
        if (c[6:5] == 2'b10) return (c[4:0] == a);
        return cur;
    endfunction

    function automatic logic [7:0] exp_status();
        return {5'b0, exp_talk, exp_listen, exp_avail};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_read(input logic [2:0] s, output logic [7:0] v);
        @(negedge clk);
        cs_n = 1'b0; rw = 1'b1; rs = s;
        @(negedge clk);
        v = rdata;
        cs_n = 1'b1;
    endtask

    task automatic cpu_write(input logic [2:0] s);
        @(negedge clk);
        cs_n = 1'b0; rw = 1'b0; rs = s;
        @(negedge clk);
        cs_n = 1'b1; rw = 1'b1;
    endtask

    task automatic check_status(input string tag);
        logic [7:0] v;
        cpu_read(3'd1, v);
        check(tag, v, exp_status());
    endtask

    // complete interlocked transfer; model updated by caller
    task automatic send_byte(input logic a, input logic [7:0] b);
        int n;
        atn = a;
        cycles(4);
        n = 0;
        while (rfd !== 1'b1 && n < 200) begin @(negedge clk); n++; end
        check("R2 rfd offered", rfd, 1);
        check("R2 dac low while ready", dac, 0);
        dbus = b;
        @(negedge clk);
        dav = 1'b1;
        n = 0;
        while (dac !== 1'b1 && n < 200) begin @(negedge clk); n++; end
        check("R2 dac raised", dac, 1);
        check("R3 rfd low with dac", rfd, 0);
        cycles(3);
        check("R3 dac held while dav", dac, 1);
        dav = 1'b0;
        n = 0;
        while (dac !== 1'b0 && n < 200) begin @(negedge clk); n++; end
        check("R3 dac released", dac, 0);
    endtask

    task automatic send_cmd(input logic [7:0] b);
        send_byte(1'b1, b);
        exp_listen = model_listen(b, exp_listen, addr_sw);
        exp_talk   = model_talk(b, exp_talk, addr_sw);
    endtask

    task automatic send_data(input logic [7:0] b);
        send_byte(1'b0, b);
        exp_avail = 1'b1;
        exp_rx    = b;
    endtask

    // R7/R9: attention low, no handshake expected
    task automatic expect_blocked(input string tag);
        bit seen = 0;
        atn = 1'b0;
        cycles(8);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (rfd) seen = 1;
        end
        check(tag, seen, 0);
        dbus = 8'h77;
        dav = 1'b1;
        cycles(12);
        check(tag, dac, 0);
        dav = 1'b0;
        cycles(6);
    endtask

    task automatic read_rx(input string tag);
        logic [7:0] v;
        cpu_read(3'd0, v);
        check(tag, v, exp_rx);
        exp_avail = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5eed_1234));
        cycles(3);
        // R1
        check("R1 rfd at reset", rfd, 0);
        check("R1 dac at reset", dac, 0);
        rst_n = 1'b1;
        cycles(2);
        check_status("R1 status after reset");

        // R7: not a listener
        expect_blocked("R7 non-listener ignores data");
        check_status("R7 status unchanged");

        // R4: foreign listen, then own listen with bit 7 set
        send_cmd(8'h2A);
        check_status("R4 other listen address");
        send_cmd(8'hA9);
        check_status("R4 own listen address bit7 ignored");

        // R8/R9/R10
        send_data(8'hA5);
        check_status("R8 data available");
        expect_blocked("R9 rfd held until read");
        @(negedge clk);
        cs_n = 1'b1; rw = 1'b1; rs = 3'd0;
        cycles(2);
        check_status("R10 deselected read no effect");
        cpu_read(3'd5, v);
        check("R10 unmapped select reads zero", v, 0);
        check_status("R10 status read keeps avail");
        // R11
        cpu_write(3'd0);
        cpu_write(3'd1);
        check_status("R11 write ignored status");
        read_rx("R8 receive register");
        check_status("R10 read clears avail");
        atn = 1'b0;
        cycles(8);
        check("R9 rfd back after read", rfd, 1);
        send_data(8'h3C);
        read_rx("R8 second byte");

        // R5
        send_cmd(8'h49);
        check_status("R5 own talk");
        send_cmd(8'h4B);
        check_status("R5 other talk clears");
        send_cmd(8'h49);
        send_cmd(8'h5F);
        check_status("R5 untalk clears");

        // R6
        send_cmd(8'h3F);
        check_status("R6 unlisten clears");
        addr_sw = 5'd31;
        cycles(2);
        send_cmd(8'h3F);
        check_status("R6 address 31 never listens");
        addr_sw = 5'd9;
        cycles(2);

        // constrained random mix
        for (int it = 0; it < 120; it++) begin
            int op = $urandom_range(0, 3);
            case (op)
                0: begin
                    logic [7:0] b;
                    case ($urandom_range(0, 6))
                        0: b = {3'b001, addr_sw};
                        1: b = {3'b010, addr_sw};
                        2: b = 8'h3F;
                        3: b = 8'h5F;
                        4: b = {3'b001, addr_sw ^ 5'd1};
                        5: b = {3'b010, addr_sw ^ 5'd4};
                        default: b = 8'($urandom);
                    endcase
                    b[7] = 1'($urandom);
                    send_cmd(b);
                    check_status("R4 R5 R6 random command");
                end
                1: begin
                    if (exp_listen && !exp_avail) begin
                        send_data(8'($urandom));
                        check_status("R8 random data");
                    end else begin
                        expect_blocked("R7 R9 random blocked");
                        check_status("R7 random blocked status");
                    end
                end
                2: begin
                    logic [2:0] s = 3'($urandom);
                    cpu_read(s, v);
                    if (s == 3'd0) begin
                        check("R8 random rx read", v, exp_rx);
                        exp_avail = 1'b0;
                    end else if (s == 3'd1) begin
                        check("R10 random status read", v, exp_status());
                    end else begin
                        check("R10 random unmapped", v, 0);
                    end
                end
                default: begin
                    cpu_write(3'($urandom));
                    check_status("R11 random write ignored");
                end
            endcase
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule